// File: doc/BRIEF.md
# GPIO Interrupt Status and Enable Unit

This unit watches a bank of already synchronized GPIO pin levels and turns selected transitions or levels into latched interrupt status. Each pin has a two-bit receive mode input and an interrupt-routing select field. Both come from configuration storage held elsewhere. A pin in rising-edge mode latches status when it goes from low to high. A pin in high-level mode latches status on every cycle it is high. A pin in either disabled mode, or whose select field is zero, never latches anything.

Software reaches the unit over a simple 32-bit register bus. The bus has a write strobe and a combinational read path. Status is kept in a group of 32-bit words that are cleared by writing one. A parallel group of read/write enable words masks the status. One shared interrupt line is the OR, over all pins, of status AND enable. A driver reads the status and enable words, services the unmasked pins, and clears them by writing their bits back as ones.

Top module: `gpio_irq_unit`

## Requirements
- R1: With receive mode 1 (rising edge) and a nonzero select field, a pin that was sampled low on one clock and is high on the next sets its status bit on that clock. A pin that stays high does not set status again after it has been cleared.
- R2: With receive mode 0 (high level) and a nonzero select field, status is set on every clock where the pin is high. A write-one clear issued while the pin is still high leaves the bit reading as set. After the pin drops, the bit stays set until it is cleared.
- R3: Receive modes 2 and 3 never set status, whatever the pin does.
- R4: A pin whose interrupt select field is all zeros never sets status, in any receive mode.
- R5: Status word k is at byte address 0x14 + 4k, for k = 0..3. Pin n is bit n%32 of word n/32. Writing a one to a status bit clears it. Writing a zero leaves it unchanged. Bus writes never set status.
- R6: If a pin's set condition occurs on the same clock as a write-one clear of its bit, the bit ends that clock set.
- R7: Enable word k is at byte address 0x24 + 4k, with the same pin mapping as the status words. It is plain read/write storage. Status is latched whether the enable bit is set or clear.
- R8: irq_o is high exactly when some pin has both its status bit and its enable bit set. It follows the registers with no added delay.
- R9: After synchronous reset, every status and enable bit is zero and irq_o is low.
- R10: Any address other than the eight word addresses reads as zero. A write to such an address changes no status or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| rx_mode_i | input | 2*NUM_PINS | Per-pin receive mode, pin n in bits 2n+1:2n (0 level, 1 rising, 2/3 off) |
| int_sel_i | input | SEL_W*NUM_PINS | Per-pin interrupt select field, pin n in bits SEL_W*n +: SEL_W |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The embedded properties check on every clock that a detector hit sets its status bit on the next clock, that a one-write without a competing hit clears it, and that a zero-write keeps it. They also check that enable words take the written value, that pins with a zero select field or a disabled mode never gain status, and that irq_o never rises without some status and some enable present. The address mapping of every pin, the refusal of a held-high edge pin to fire again, the level pin reasserting through a clear, unused addresses, and the masking of one word's status by another word's enable can only be shown by the bench's per-pin sweeps and directed sequences.

// File: rtl/gpio_irq_pkg.sv
// Package: shared encodings for the GPIO interrupt unit.
// Assumes the receive mode field is two bits wide.
package gpio_irq_pkg;

    // Receive mode encoding of a pin; both upper codes disable detection.
    typedef enum logic [1:0] {
        RX_LEVEL_HIGH = 2'd0,
        RX_RISE_EDGE  = 2'd1,
        RX_OFF        = 2'd2,
        RX_OFF_ALT    = 2'd3
    } rx_mode_e;

    localparam int unsigned BUS_W = 32;

endpackage

// File: rtl/gpio_irq_detect.sv
// Module: per-pin trigger detector.
// Produces a one-cycle hit when the pin meets its trigger condition.
// Assumes pin_i is already synchronized to clk. The edge history is
// cleared by reset, so a pin high on the first clock counts as a rise.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    logic prev_q;

    // Remember the previous pin sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    // Decide whether this cycle's sample is a trigger.
    always_comb begin
        hit_o = 1'b0;
        if (sel_i != '0) begin
            case (rx_mode_e'(mode_i))
                RX_LEVEL_HIGH: hit_o = pin_i;
                RX_RISE_EDGE:  hit_o = pin_i & ~prev_q;
                default:       hit_o = 1'b0;
            endcase
        end
    end

    // R1: a held-high pin in edge mode produces no second hit
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && $past(pin_i) && pin_i && $past(rst_n)) |-> !hit_o);

endmodule

// File: rtl/gpio_irq_regs.sv
// Module: status and enable word storage with bus decode.
// Status bits are set by detector hits and cleared by one-writes, and a
// hit wins over a clear on the same clock. Enable bits are plain storage.
// Assumes NUM_PINS is a multiple of WORD_W.
module gpio_irq_regs #(
    parameter int unsigned            NUM_PINS    = 128,
    parameter int unsigned            WORD_W      = 32,
    parameter int unsigned            ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]      STATUS_BASE = 'h14,
    parameter logic [ADDR_W-1:0]      ENABLE_BASE = 'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit_i,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    output logic [NUM_PINS-1:0] status_o,
    output logic [NUM_PINS-1:0] enable_o
);

    localparam int unsigned NUM_WORDS = NUM_PINS / WORD_W;
    localparam int unsigned STRIDE    = WORD_W / 8;

    logic [WORD_W-1:0]    status_q [NUM_WORDS];
    logic [WORD_W-1:0]    enable_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] st_sel;
    logic [NUM_WORDS-1:0] en_sel;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] ST_ADDR = STATUS_BASE + ADDR_W'(STRIDE * w);
        localparam logic [ADDR_W-1:0] EN_ADDR = ENABLE_BASE + ADDR_W'(STRIDE * w);

        assign st_sel[w] = (addr_i == ST_ADDR);
        assign en_sel[w] = (addr_i == EN_ADDR);

        // Latch hits and apply write-one clears; hits take priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[w] <= '0;
            else
                status_q[w] <= (status_q[w] & ~((wr_i && st_sel[w]) ? wdata_i : '0))
                             | hit_i[w*WORD_W +: WORD_W];
        end

        // Store enable words written over the bus.
        always_ff @(posedge clk) begin
            if (!rst_n)                 enable_q[w] <= '0;
            else if (wr_i && en_sel[w]) enable_q[w] <= wdata_i;
        end

        assign status_o[w*WORD_W +: WORD_W] = status_q[w];
        assign enable_o[w*WORD_W +: WORD_W] = enable_q[w];
    end

    // Return the addressed word, or zero for any other address.
    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (st_sel[w]) rdata_o = status_q[w];
            if (en_sel[w]) rdata_o = enable_q[w];
        end
    end

    for (genvar b = 0; b < NUM_PINS; b++) begin : g_chk
        localparam int unsigned W = b / WORD_W;
        localparam int unsigned B = b % WORD_W;

        // R1/R2: a detector hit is latched on the next clock
        p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[b] |=> status_o[b]);

        // R5: a one-write with no competing hit clears the bit
        p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && st_sel[W] && wdata_i[B] && !hit_i[b]) |=> !status_o[b]);

        // R5: a zero-write keeps a set bit
        p_w0_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && st_sel[W] && !wdata_i[B] && status_o[b]) |=> status_o[b]);

        // R6: set wins over a same-cycle clear
        p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && st_sel[W] && wdata_i[B] && hit_i[b]) |=> status_o[b]);

        // R7: enable bits take the written value
        p_enable_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && en_sel[W]) |=> (enable_o[b] == $past(wdata_i[B])));
    end

endmodule

// File: rtl/gpio_irq_unit.sv
// Module: top of the GPIO interrupt status and enable unit.
// One detector per pin feeds the status words; the shared interrupt is
// the OR of status AND enable over all pins. Assumes pins arrive
// synchronized and configuration fields are held stable by their owner.
module gpio_irq_unit #(
    parameter int unsigned       NUM_PINS    = 128,
    parameter int unsigned       SEL_W       = 8,
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_BASE = 'h14,
    parameter logic [ADDR_W-1:0] ENABLE_BASE = 'h24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_i,
    input  logic [2*NUM_PINS-1:0]     rx_mode_i,
    input  logic [SEL_W*NUM_PINS-1:0] int_sel_i,
    input  logic                      bus_wr_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [31:0]               bus_wdata_i,
    output logic [31:0]               bus_rdata_o,
    output logic                      irq_o
);

    localparam int unsigned WORD_W = gpio_irq_pkg::BUS_W;

    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] enable;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_irq_detect #(.SEL_W(SEL_W)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[i]),
            .mode_i (rx_mode_i[2*i +: 2]),
            .sel_i  (int_sel_i[SEL_W*i +: SEL_W]),
            .hit_o  (hit[i])
        );

        // R4: a zero select field keeps a clear status bit clear
        p_zero_sel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[i] && int_sel_i[SEL_W*i +: SEL_W] == '0) |=> !status[i]);

        // R3: modes 2 and 3 keep a clear status bit clear
        p_off_mode_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[i] && rx_mode_i[2*i+1]) |=> !status[i]);
    end

    gpio_irq_regs #(
        .NUM_PINS    (NUM_PINS),
        .WORD_W      (WORD_W),
        .ADDR_W      (ADDR_W),
        .STATUS_BASE (STATUS_BASE),
        .ENABLE_BASE (ENABLE_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .rdata_o  (bus_rdata_o),
        .status_o (status),
        .enable_o (enable)
    );

    // Combine unmasked status into the shared interrupt line.
    assign irq_o = |(status & enable);

    // R8: the line never rises without both some status and some enable
    p_irq_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status != '0 && enable != '0));

    // R9: registers are empty on the first clock after reset
    p_reset_clean_r9: assert property (@(posedge clk)
        $past(!rst_n) |-> (status == '0 && enable == '0 && !irq_o));

endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;

    localparam int N = 128;
    localparam int S = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0]   pin = '0;
    logic [2*N-1:0] mode = '0;
    logic [S*N-1:0] sel = '0;
    logic         wr = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;

    int n_vec = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .rx_mode_i(mode),
        .int_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st_addr(input int p);
        return 8'(8'h14 + 4 * (p / 32));
    endfunction

    function automatic logic [7:0] en_addr(input int p);
        return 8'(8'h24 + 4 * (p / 32));
    endfunction

    function automatic logic [31:0] bitof(input int p);
        return 32'h1 << (p % 32);
    endfunction

    // Called at a falling edge; returns at the next falling edge with the write applied.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_all(input logic [1:0] m, input logic [S-1:0] s);
        for (int i = 0; i < N; i++) begin
            mode[2*i +: 2] = m;
            sel[S*i +: S]  = s;
        end
    endtask

    task automatic expect_word(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] pat;
        set_all(2'd1, 8'h01);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of all words and the line
        for (int k = 0; k < 4; k++) begin
            expect_word("R9 status", 8'(8'h14 + 4*k), 32'h0);
            expect_word("R9 enable", 8'(8'h24 + 4*k), 32'h0);
        end
        check("R9 irq", {31'h0, irq}, 32'h0);

        // R7: enable words read back what was written
        for (int k = 0; k < 4; k++) bus_write(8'(8'h24 + 4*k), 32'hA5C3_0F00 ^ (32'h1111_1111 * k));
        for (int k = 0; k < 4; k++)
            expect_word("R7 enable rw", 8'(8'h24 + 4*k), 32'hA5C3_0F00 ^ (32'h1111_1111 * k));

        // R10: unused addresses read zero and writes to them change nothing
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        expect_word("R10 read 0x34", 8'h34, 32'h0);
        expect_word("R10 read 0x10", 8'h10, 32'h0);
        expect_word("R10 read 0x16", 8'h16, 32'h0);
        for (int k = 0; k < 4; k++) begin
            expect_word("R10 enable kept", 8'(8'h24 + 4*k), 32'hA5C3_0F00 ^ (32'h1111_1111 * k));
            expect_word("R10 status kept", 8'(8'h14 + 4*k), 32'h0);
        end
        for (int k = 0; k < 4; k++) bus_write(8'(8'h24 + 4*k), 32'h0);

        // R1/R5/R7/R8: per-pin rising-edge sweep over all pins
        for (int p = 0; p < N; p++) begin
            pin[p] = 1'b1;
            @(negedge clk);
            expect_word("R1/R5 edge latched", st_addr(p), bitof(p));
            check("R7 masked while status set", {31'h0, irq}, 32'h0);
            bus_write(en_addr(p), bitof(p));
            check("R8 irq unmasked", {31'h0, irq}, 32'h1);
            bus_write(st_addr(p), bitof(p));
            check("R8 irq after clear", {31'h0, irq}, 32'h0);
            repeat (2) @(negedge clk);
            expect_word("R1 held high no refire", st_addr(p), 32'h0);
            bus_write(en_addr(p), 32'h0);
            pin[p] = 1'b0;
            @(negedge clk);
        end

        // R2: level mode reasserts through a clear and holds after the pin drops
        mode[2*70 +: 2] = 2'd0;
        pin[70] = 1'b1;
        @(negedge clk);
        expect_word("R2 level set", st_addr(70), bitof(70));
        bus_write(st_addr(70), bitof(70));
        expect_word("R2 clear while high", st_addr(70), bitof(70));
        pin[70] = 1'b0;
        repeat (2) @(negedge clk);
        expect_word("R2 held after drop", st_addr(70), bitof(70));
        bus_write(st_addr(70), bitof(70));
        expect_word("R2 cleared when low", st_addr(70), 32'h0);
        mode[2*70 +: 2] = 2'd1;

        // R6/R5: new edge on the clear's clock, and zero-writes keep status
        pin[100] = 1'b1;
        @(negedge clk);
        pin[100] = 1'b0;
        @(negedge clk);
        pin[100] = 1'b1;
        bus_write(st_addr(100), bitof(100));
        expect_word("R6 set beats clear", st_addr(100), bitof(100));
        bus_write(st_addr(100), 32'h0);
        expect_word("R5 zero write keeps", st_addr(100), bitof(100));
        bus_write(st_addr(100), ~bitof(100));
        expect_word("R5 other bits only", st_addr(100), bitof(100));
        pin[100] = 1'b0;
        bus_write(st_addr(100), bitof(100));
        expect_word("R5 cleared", st_addr(100), 32'h0);

        // R8/R7: status in two words, only one enabled
        pin[3] = 1'b1; pin[127] = 1'b1;
        @(negedge clk);
        pin[3] = 1'b0; pin[127] = 1'b0;
        bus_write(en_addr(3), bitof(3));
        check("R8 irq from word 0", {31'h0, irq}, 32'h1);
        bus_write(st_addr(3), bitof(3));
        check("R8 word 3 status masked", {31'h0, irq}, 32'h0);
        expect_word("R7 masked status kept", st_addr(127), bitof(127));
        bus_write(en_addr(127), bitof(127));
        check("R8 irq from word 3", {31'h0, irq}, 32'h1);
        bus_write(st_addr(127), bitof(127));
        bus_write(en_addr(3), 32'h0);
        bus_write(en_addr(127), 32'h0);
        check("R8 irq idle", {31'h0, irq}, 32'h0);

        // R3: both disabled modes, all pins toggling
        for (int m = 2; m < 4; m++) begin
            set_all(2'(m), 8'hFF);
            pin = '1;
            repeat (2) @(negedge clk);
            pin = '0;
            @(negedge clk);
            for (int k = 0; k < 4; k++)
                expect_word("R3 disabled mode", 8'(8'h14 + 4*k), 32'h0);
        end

        // R4: zero select field in both active modes
        for (int m = 0; m < 2; m++) begin
            set_all(2'(m), 8'h00);
            pin = '1;
            repeat (2) @(negedge clk);
            pin = '0;
            @(negedge clk);
            for (int k = 0; k < 4; k++)
                expect_word("R4 zero select", 8'(8'h14 + 4*k), 32'h0);
        end
        check("R4 irq quiet", {31'h0, irq}, 32'h0);

        finish_run();
    end

endmodule